// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns a single 32-bit software interrupt request write into set-pending pulses for up to eight CPU interfaces. The write names one of sixteen software interrupt IDs and picks a target mode. The mode can be an explicit CPU mask, every CPU except the requester, or only the requester. The block then decides, separately for each targeted CPU, whether the interrupt may be delivered. That decision uses the write's security state, a requested-security bit carried in the write, and the target CPU's own group setting for that interrupt ID.

The group settings (one bit per interrupt ID per CPU, where 1 means Group 1 and 0 means Group 0) come in as inputs. So do the 2-bit Non-secure access levels (one per interrupt ID per CPU). The result is a registered pulse vector. Each CPU has a 16-bit slice, and bit `cpu*16 + id` is high for exactly one cycle when interrupt `id` must become pending on that CPU. A global enable input gates all dispatch.

Top module: `sgi_dispatch`

## Requirements
- R1: The write word is decoded as follows. Bits [3:0] give the interrupt ID, bit 15 is the requested-security bit, bits [23:16] are the CPU mask (bit n means CPU n), and bits [25:24] are the mode. Bits [14:4] and [31:26] have no effect on the output.
- R2: Mode 00 targets each CPU whose mask bit is 1. A mask of zero produces no pulse.
- R3: Mode 01 targets every implemented CPU except the one given by `wrCpuId`.
- R4: Mode 10 targets only the CPU given by `wrCpuId`.
- R5: Mode 11 produces no pulse on any CPU.
- R6: For a Secure write (`wrNonSecure`=0) with bit 15 at 0, a targeted CPU receives the pulse only if its group bit for that ID is 0. This is decided independently for each target.
- R7: For a Secure write with bit 15 at 1, a targeted CPU receives the pulse only if its group bit for that ID is 1.
- R8: For a Non-secure write, bit 15 is ignored. A targeted CPU receives the pulse if its group bit is 1, or if its group bit is 0 and its 2-bit access level for that ID is nonzero.
- R9: The pulse appears in the cycle after the cycle in which `wrValid` is high, and lasts one cycle. No pulse appears without a write.
- R10: While `distEnable` is low, a write produces no pulse.
- R11: During reset and in the first cycle after it, `setPend` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| distEnable | input | 1 | Global dispatch enable |
| wrValid | input | 1 | Write strobe for the request word |
| wrData | input | 32 | Request word |
| wrCpuId | input | 3 | ID of the requesting CPU |
| wrNonSecure | input | 1 | 1 if the write is Non-secure |
| sgiGroup | input | NUM_CPUS*16 | Group bit per CPU per ID, 1 = Group 1 |
| nsAccess | input | NUM_CPUS*32 | 2-bit Non-secure access level per CPU per ID |
| setPend | output | NUM_CPUS*16 | One-cycle set-pending pulses, bit cpu*16+id |

## Verification
The only internal state is the output register, so any fault in decode or in the qualification logic appears at the ports exactly one cycle after the offending write. It shows up as a pulse on the wrong CPU slice, a pulse on the wrong ID bit, or a pulse that is missing. A stuck register bit would instead show as a pulse that lasts past its single cycle, or as a nonzero value on idle cycles. The bench therefore samples both the cycle after each write and the cycle after that.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int SGI_COUNT = 16;
  localparam int ID_W      = $clog2(SGI_COUNT);
  localparam int MASK_W    = 8;
  localparam int CPU_ID_W  = $clog2(MASK_W);

  typedef enum logic [1:0] {
    FILT_LIST   = 2'b00,
    FILT_OTHERS = 2'b01,
    FILT_SELF   = 2'b10,
    FILT_RSVD   = 2'b11
  } filt_e;

  typedef struct packed {
    logic                fire;
    filt_e               mode;
    logic [ID_W-1:0]     sgiId;
    logic [MASK_W-1:0]   mask;
    logic                nsatt;
    logic                nonSecure;
    logic [CPU_ID_W-1:0] reqCpu;
  } dispatch_s;
endpackage

// File: rtl/sgi_ctrl.sv
module sgi_ctrl
  import sgi_pkg::*;
(
  input  logic                distEnable,
  input  logic                wrValid,
  input  logic [31:0]         wrData,
  input  logic [CPU_ID_W-1:0] wrCpuId,
  input  logic                wrNonSecure,
  output dispatch_s           cmd
);
  filt_e mode;

  always_comb begin
    mode          = filt_e'(wrData[25:24]);
    cmd.mode      = mode;
    cmd.sgiId     = wrData[ID_W-1:0];
    cmd.mask      = wrData[23:16];
    cmd.nsatt     = wrData[15];
    cmd.nonSecure = wrNonSecure;
    cmd.reqCpu    = wrCpuId;
    // reserved mode never fires; disabled distributor never fires
    cmd.fire      = wrValid && distEnable && (mode != FILT_RSVD);
  end
endmodule

// File: rtl/sgi_datapath.sv
module sgi_datapath
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dispatch_s                   cmd,
  input  logic [NUM_CPUS*SGI_COUNT-1:0]   sgiGroup,
  input  logic [NUM_CPUS*SGI_COUNT*2-1:0] nsAccess,
  output logic [NUM_CPUS*SGI_COUNT-1:0]   setPend
);
  localparam int VEC_W = NUM_CPUS * SGI_COUNT;

  logic [VEC_W-1:0] nxtPend;

  always_comb begin
    logic       isTarget;
    logic       grp;
    logic [1:0] lvl;
    logic       secOk;
    int         bitIdx;
    nxtPend = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      unique case (cmd.mode)
        FILT_LIST:   isTarget = cmd.mask[c];
        FILT_OTHERS: isTarget = (cmd.reqCpu != CPU_ID_W'(c));
        FILT_SELF:   isTarget = (cmd.reqCpu == CPU_ID_W'(c));
        default:     isTarget = 1'b0;
      endcase
      bitIdx = c * SGI_COUNT + int'(cmd.sgiId);
      grp    = sgiGroup[bitIdx];
      lvl    = nsAccess[bitIdx*2 +: 2];
      if (cmd.nonSecure) secOk = grp || (lvl != 2'b00);
      else               secOk = (cmd.nsatt == grp);
      nxtPend[bitIdx] = cmd.fire && isTarget && secOk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) setPend <= '0;
    else       setPend <= nxtPend;
  end

  generate
    for (genvar g = 0; g < NUM_CPUS; g++) begin : g_chk
      logic [SGI_COUNT-1:0] slice;
      assign slice = setPend[g*SGI_COUNT +: SGI_COUNT];

      a_r9_needs_write: assert property (@(posedge clk) disable iff (!rstN)
        (|slice) |-> $past(cmd.fire));
      a_r9_single_id: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0(slice));
      a_r5_reserved_silent: assert property (@(posedge clk) disable iff (!rstN)
        (cmd.mode == FILT_RSVD) |=> (slice == '0));
      a_r4_self_only: assert property (@(posedge clk) disable iff (!rstN)
        (cmd.mode == FILT_SELF && cmd.reqCpu != CPU_ID_W'(g)) |=> (slice == '0));
      a_r3_skip_requester: assert property (@(posedge clk) disable iff (!rstN)
        (cmd.mode == FILT_OTHERS && cmd.reqCpu == CPU_ID_W'(g)) |=> (slice == '0));
    end
  endgenerate
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             distEnable,
  input  logic                             wrValid,
  input  logic [31:0]                      wrData,
  input  logic [2:0]                       wrCpuId,
  input  logic                             wrNonSecure,
  input  logic [NUM_CPUS*16-1:0]           sgiGroup,
  input  logic [NUM_CPUS*32-1:0]           nsAccess,
  output logic [NUM_CPUS*16-1:0]           setPend
);
  dispatch_s cmd;

  sgi_ctrl u_ctrl (
    .distEnable (distEnable),
    .wrValid    (wrValid),
    .wrData     (wrData),
    .wrCpuId    (wrCpuId),
    .wrNonSecure(wrNonSecure),
    .cmd        (cmd)
  );

  sgi_datapath #(.NUM_CPUS(NUM_CPUS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .sgiGroup(sgiGroup),
    .nsAccess(nsAccess),
    .setPend (setPend)
  );

  a_r10_disabled_silent: assert property (@(posedge clk) disable iff (!rstN)
    !distEnable |=> (setPend == '0));
  a_r11_reset_clear: assert property (@(posedge clk)
    !rstN |=> (setPend == '0));
endmodule

// File: tb/sgi_dispatch_tb.sv
`timescale 1ns/1ps
module sgi_dispatch_tb;
  localparam int NC = 8;
  localparam int VW = NC * 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          distEnable = 1'b1;
  logic          wrValid = 1'b0;
  logic [31:0]   wrData = '0;
  logic [2:0]    wrCpuId = '0;
  logic          wrNonSecure = 1'b0;
  logic [VW-1:0] sgiGroup = '0;
  logic [NC*32-1:0] nsAccess = '0;
  logic [VW-1:0] setPend;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sgi_dispatch #(.NUM_CPUS(NC)) u_dut (
    .clk(clk), .rstN(rstN), .distEnable(distEnable), .wrValid(wrValid),
    .wrData(wrData), .wrCpuId(wrCpuId), .wrNonSecure(wrNonSecure),
    .sgiGroup(sgiGroup), .nsAccess(nsAccess), .setPend(setPend)
  );

  function automatic logic [31:0] mk(input logic [1:0] mode, input logic [7:0] mask,
                                     input logic nsatt, input logic [3:0] id);
    return {6'b0, mode, mask, nsatt, 11'b0, id};
  endfunction

  // expected pattern: CPUs in 'cpus' receive interrupt 'id'
  function automatic logic [VW-1:0] pat(input logic [7:0] cpus, input int id);
    logic [VW-1:0] v = '0;
    for (int c = 0; c < NC; c++) if (cpus[c]) v[c*16 + id] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // issue one write; return output in the following cycle and the one after
  task automatic doWrite(input logic [31:0] d, input logic [2:0] cpu, input logic ns,
                         output logic [VW-1:0] first, output logic [VW-1:0] second);
    @(negedge clk);
    wrValid = 1'b1; wrData = d; wrCpuId = cpu; wrNonSecure = ns;
    @(negedge clk);
    wrValid = 1'b0; wrData = '0;
    first = setPend;
    @(negedge clk);
    second = setPend;
  endtask

  task automatic testReset();
    chk("R11 in reset", setPend, '0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R11 after reset", setPend, '0);
  endtask

  task automatic testList();
    logic [VW-1:0] a, b;
    sgiGroup = '0; nsAccess = '0;
    doWrite(mk(2'b00, 8'b0010_0110, 1'b0, 4'd5), 3'd0, 1'b0, a, b);
    chk("R2 mask list", a, pat(8'b0010_0110, 5));
    chk("R9 pulse ends", b, '0);
    doWrite(mk(2'b00, 8'h00, 1'b0, 4'd5), 3'd0, 1'b0, a, b);
    chk("R2 empty mask", a, '0);
    doWrite(mk(2'b00, 8'h81, 1'b0, 4'd15), 3'd2, 1'b0, a, b);
    chk("R2 edge cpus id15", a, pat(8'h81, 15));
  endtask

  task automatic testModes();
    logic [VW-1:0] a, b;
    sgiGroup = '0; nsAccess = '0;
    doWrite(mk(2'b01, 8'h00, 1'b0, 4'd3), 3'd3, 1'b0, a, b);
    chk("R3 others", a, pat(8'b1111_0111, 3));
    doWrite(mk(2'b10, 8'hFF, 1'b0, 4'd7), 3'd6, 1'b0, a, b);
    chk("R4 self", a, pat(8'b0100_0000, 7));
    doWrite(mk(2'b11, 8'hFF, 1'b0, 4'd7), 3'd6, 1'b0, a, b);
    chk("R5 reserved", a, '0);
  endtask

  task automatic testReserved();
    logic [VW-1:0] a, b;
    sgiGroup = '0; nsAccess = '0;
    doWrite(mk(2'b00, 8'h0C, 1'b0, 4'd2) | 32'hFC00_7FF0, 3'd0, 1'b0, a, b);
    chk("R1 reserved bits ignored", a, pat(8'h0C, 2));
  endtask

  task automatic testSecure();
    logic [VW-1:0] a, b;
    nsAccess = '0;
    sgiGroup = '0;
    for (int c = 0; c < NC; c += 2) sgiGroup[c*16 + 9] = 1'b1; // even CPUs: Group 1
    doWrite(mk(2'b00, 8'hFF, 1'b0, 4'd9), 3'd0, 1'b0, a, b);
    chk("R6 secure nsatt0", a, pat(8'hAA, 9));
    doWrite(mk(2'b00, 8'hFF, 1'b1, 4'd9), 3'd0, 1'b0, a, b);
    chk("R7 secure nsatt1", a, pat(8'h55, 9));
  endtask

  task automatic testNonSecure();
    logic [VW-1:0] a, b;
    sgiGroup = '0; nsAccess = '0;
    for (int c = 0; c < NC; c += 2) sgiGroup[c*16 + 4] = 1'b1;
    nsAccess[(1*16 + 4)*2 +: 2] = 2'b01;  // CPU1 Group 0 with access
    nsAccess[(3*16 + 5)*2 +: 2] = 2'b11;  // other ID: must not matter
    doWrite(mk(2'b00, 8'hFF, 1'b0, 4'd4), 3'd0, 1'b1, a, b);
    chk("R8 nonsecure nsatt0", a, pat(8'b0101_0111, 4));
    doWrite(mk(2'b00, 8'hFF, 1'b1, 4'd4), 3'd0, 1'b1, a, b);
    chk("R8 nonsecure nsatt1 ignored", a, pat(8'b0101_0111, 4));
  endtask

  task automatic testEnableIdle();
    logic [VW-1:0] a, b;
    sgiGroup = '0; nsAccess = '0;
    distEnable = 1'b0;
    doWrite(mk(2'b00, 8'hFF, 1'b0, 4'd1), 3'd0, 1'b0, a, b);
    chk("R10 disabled", a, '0);
    distEnable = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 idle no pulse", setPend, '0);
    doWrite(mk(2'b00, 8'hFF, 1'b0, 4'd1), 3'd0, 1'b0, a, b);
    chk("R10 re-enabled", a, pat(8'hFF, 1));
    chk("R9 single cycle", b, '0);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testList();
    testModes();
    testReserved();
    testSecure();
    testNonSecure();
    testEnableIdle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule